// File: doc/BRIEF.md
# Bit-Addressed Bidirectional Printer Port Controller

This block puts up to four printer-style 8-bit parallel ports on a host that has two buses. One is a bit-serial I/O bus, where every access names a single bit: the host sets it, clears it, or tests it. The other is an ordinary byte-wide memory bus. All handshake, status and mode bits of a port are reached one bit at a time on the bit bus. The data byte of each port is a normal memory location.

Each port has these parts:
- an 8-bit data latch;
- a direction bit, which selects between driving the data pins and sampling them;
- five status inputs, each sampled through a two-flop synchroniser;
- four handshake outputs, with fixed pin polarities;
- a spare output;
- an LED flag;
- a card-present flag, which always reads 1.

The select-printer control also acts as the enable of an attached ternary output stage.

Bit-bus and memory reads are combinational from the address. A write takes effect at the next rising clock edge.

Top module: `bitio_parport`

## Requirements
- R1: After synchronous reset every port has these values:
  - data-path state: output mode (`pd_oe`=1), data latch 0x00 (`pd_out`=0x00);
  - handshake pins: `ctl_strobe_n`=1, `ctl_autolf_n`=1, `ctl_init`=0, `ctl_selpr_n`=1;
  - flags: `ctl_spare`=0, `tern_en`=0, `led`=0.
- R2: Port k answers on the bit bus when bits 15:4 of `bio_addr` equal those of 0x1000 + 0x10·k, for k = 0 to 3. The bit index is `bio_addr[3:0]`. On any other bit-bus address a write changes no port and a test returns 0.
- R3: A bit write (`bio_wr`=1) loads `bio_wval` into one bit of the addressed port, chosen by the index:
  - 0: strobe;
  - 1: auto-linefeed;
  - 2: initialise;
  - 3: select-printer;
  - 4: spare;
  - 5: direction (1 = input, 0 = output);
  - 6: LED.
- R4: Pin polarity:
  - strobe, auto-linefeed and select-printer are driven inverted, so a stored 1 gives pin level 0;
  - initialise and spare are driven true;
  - `pd_oe` is the inverse of the direction bit.
- R5: `tern_en` of a port equals its stored select-printer bit (write index 3).
- R6: A bit test returns, by index:
  - 0: card present, always 1;
  - 1: direction;
  - 2: LED;
  - 3: error input;
  - 4: select input;
  - 5: paper-end input;
  - 6: acknowledge input;
  - 7: busy input.
  Status inputs reach the test path through two flip-flops.
- R7: A bit test of index 8 to 15 returns 0. A bit write to index 7 to 15 changes nothing.
- R8: The data register of port k is at memory byte address 0x5000 + 2·k. A memory write there loads the latch, which drives `pd_out` at the next clock.
- R9: A memory read of a data register returns the latch in output mode. In input mode it returns `pd_in` after a two-flop synchroniser. The latch keeps its value across direction changes.
- R10: A memory read of any address other than the four data registers returns 0x00. A memory write there changes no latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bio_addr | input | 16 | Bit-bus address (base in 15:4, bit index in 3:0) |
| bio_wr | input | 1 | Bit write strobe |
| bio_wval | input | 1 | Value written by a bit write (1 set, 0 clear) |
| bio_rbit | output | 1 | Result of a bit test at `bio_addr` |
| mem_addr | input | 16 | Memory byte address |
| mem_wr | input | 1 | Memory byte write strobe |
| mem_wdata | input | 8 | Memory write byte |
| mem_rdata | output | 8 | Memory read byte at `mem_addr` |
| pd_in | input | 32 | Data pin levels, 8 bits per port |
| pd_out | output | 32 | Data latch values, 8 bits per port |
| pd_oe | output | 4 | Data pin drive enable per port |
| st_err | input | 4 | Error input per port |
| st_sel | input | 4 | Select input per port |
| st_pend | input | 4 | Paper-end input per port |
| st_ack | input | 4 | Acknowledge input per port |
| st_busy | input | 4 | Busy input per port |
| ctl_strobe_n | output | 4 | Strobe pin level per port |
| ctl_autolf_n | output | 4 | Auto-linefeed pin level per port |
| ctl_init | output | 4 | Initialise pin level per port |
| ctl_selpr_n | output | 4 | Select-printer pin level per port |
| ctl_spare | output | 4 | Spare output per port |
| tern_en | output | 4 | Ternary stage enable per port |
| led | output | 4 | LED flag per port |

## Verification
The assertions take for granted that the bit-bus and memory addresses are stable for the whole cycle around a write strobe. They also assume that at most one port decodes any bit-bus address, which the fixed base spacing guarantees.

The stimulus changes every input only on the falling clock edge and holds it for a full cycle, so each write is seen by exactly one rising edge. Status and data pins are changed only while no test is pending, and at least three cycles pass before they are read, which leaves room for the two-flop synchronisers.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam int DW       = 8;
    localparam int IDX_W    = 4;
    localparam logic [15:0] BIO_BASE0 = 16'h1000;
    localparam logic [15:0] BIO_STEP  = 16'h0010;
    localparam logic [15:0] MEM_BASE0 = 16'h5000;
    localparam logic [15:0] MEM_STEP  = 16'h0002;

    // bit-write indices
    localparam logic [IDX_W-1:0] WI_STROBE = 4'd0;
    localparam logic [IDX_W-1:0] WI_AUTOLF = 4'd1;
    localparam logic [IDX_W-1:0] WI_INIT   = 4'd2;
    localparam logic [IDX_W-1:0] WI_SELPR  = 4'd3;
    localparam logic [IDX_W-1:0] WI_SPARE  = 4'd4;
    localparam logic [IDX_W-1:0] WI_DIR    = 4'd5;
    localparam logic [IDX_W-1:0] WI_LED    = 4'd6;

    // bit-test indices
    localparam logic [IDX_W-1:0] RI_PRES   = 4'd0;
    localparam logic [IDX_W-1:0] RI_DIR    = 4'd1;
    localparam logic [IDX_W-1:0] RI_LED    = 4'd2;
    localparam logic [IDX_W-1:0] RI_ERR    = 4'd3;
    localparam logic [IDX_W-1:0] RI_SEL    = 4'd4;
    localparam logic [IDX_W-1:0] RI_PEND   = 4'd5;
    localparam logic [IDX_W-1:0] RI_ACK    = 4'd6;
    localparam logic [IDX_W-1:0] RI_BUSY   = 4'd7;

    typedef struct packed {
        logic spare;
        logic selpr;
        logic init;
        logic autolf;
        logic strobe;
    } ctl_t;

    typedef struct packed {
        logic busy;
        logic ack;
        logic pend;
        logic sel;
        logic err;
    } stat_t;

    localparam int NSTAT = $bits(stat_t);

    function automatic logic [15:0] bio_base(input int k);
        return BIO_BASE0 + (BIO_STEP * 16'(k));
    endfunction

    function automatic logic [15:0] mem_base(input int k);
        return MEM_BASE0 + (MEM_STEP * 16'(k));
    endfunction
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pp_port.sv
module pp_port
    import pp_pkg::*;
#(
    parameter logic [15:0] BIO_BASE = 16'h1000,
    parameter logic [15:0] MEM_BASE = 16'h5000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [15:0]   bio_addr,
    input  logic          bio_wr,
    input  logic          bio_wval,
    input  logic [15:0]   mem_addr,
    input  logic          mem_wr,
    input  logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] pd_in,
    input  stat_t         st_pins,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe,
    output logic          strobe_n,
    output logic          autolf_n,
    output logic          init_p,
    output logic          selpr_n,
    output logic          spare_p,
    output logic          tern_p,
    output logic          led_p,
    output logic          bio_hit_o,
    output logic          bio_rbit_o,
    output logic          mem_hit_o,
    output logic [DW-1:0] mem_rdata_o
);
    logic [IDX_W-1:0] idx;
    ctl_t             ctl;
    logic             dir_in;
    logic             led_q;
    logic [DW-1:0]    latch;
    stat_t            st_s;
    logic [DW-1:0]    din_s;
    logic             tbit;

    assign idx       = bio_addr[IDX_W-1:0];
    assign bio_hit_o = (bio_addr[15:IDX_W] == BIO_BASE[15:IDX_W]);
    assign mem_hit_o = (mem_addr == MEM_BASE);

    pp_sync #(.W(NSTAT)) u_stat_sync (.clk(clk), .rst(rst), .d(st_pins), .q(st_s));
    pp_sync #(.W(DW))    u_data_sync (.clk(clk), .rst(rst), .d(pd_in),   .q(din_s));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '0;
            dir_in <= 1'b0;
            led_q  <= 1'b0;
            latch  <= '0;
        end else begin
            if (bio_wr && bio_hit_o) begin
                case (idx)
                    WI_STROBE: ctl.strobe <= bio_wval;
                    WI_AUTOLF: ctl.autolf <= bio_wval;
                    WI_INIT:   ctl.init   <= bio_wval;
                    WI_SELPR:  ctl.selpr  <= bio_wval;
                    WI_SPARE:  ctl.spare  <= bio_wval;
                    WI_DIR:    dir_in     <= bio_wval;
                    WI_LED:    led_q      <= bio_wval;
                    default:   ;
                endcase
            end
            if (mem_wr && mem_hit_o) begin
                latch <= mem_wdata;
            end
        end
    end

    always_comb begin
        case (idx)
            RI_PRES: tbit = 1'b1;
            RI_DIR:  tbit = dir_in;
            RI_LED:  tbit = led_q;
            RI_ERR:  tbit = st_s.err;
            RI_SEL:  tbit = st_s.sel;
            RI_PEND: tbit = st_s.pend;
            RI_ACK:  tbit = st_s.ack;
            RI_BUSY: tbit = st_s.busy;
            default: tbit = 1'b0;
        endcase
    end

    assign bio_rbit_o  = bio_hit_o & tbit;
    assign mem_rdata_o = mem_hit_o ? (dir_in ? din_s : latch) : '0;

    assign pd_out   = latch;
    assign pd_oe    = ~dir_in;
    assign strobe_n = ~ctl.strobe;
    assign autolf_n = ~ctl.autolf;
    assign init_p   = ctl.init;
    assign selpr_n  = ~ctl.selpr;
    assign spare_p  = ctl.spare;
    assign tern_p   = ctl.selpr;
    assign led_p    = led_q;

    // R3: a strobe write lands on the pin one edge later, inverted (R4)
    a_r3_strobe_write: assert property (@(posedge clk) disable iff (rst)
        (bio_wr && bio_hit_o && idx == WI_STROBE) |=> (strobe_n == !$past(bio_wval)));

    // R5: select-printer write drives the ternary enable
    a_r5_tern_follows: assert property (@(posedge clk) disable iff (rst)
        (bio_wr && bio_hit_o && idx == WI_SELPR) |=> (tern_p == $past(bio_wval)));

    // R7: writes at unused indices leave every stored bit alone
    a_r7_reserved_write: assert property (@(posedge clk) disable iff (rst)
        (bio_wr && idx > WI_LED && !(mem_wr && mem_hit_o)) |=>
            ($stable(ctl) && $stable(dir_in) && $stable(led_q) && $stable(pd_out)));

    // R7: tests at unused indices read 0
    a_r7_reserved_read: assert property (@(posedge clk) disable iff (rst)
        (idx > RI_BUSY) |-> !bio_rbit_o);

    // R8: memory write loads the data latch
    a_r8_latch_write: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_hit_o) |=> (pd_out == $past(mem_wdata)));

    // R9: output-mode reads return what drives the pins
    a_r9_out_readback: assert property (@(posedge clk) disable iff (rst)
        (mem_hit_o && pd_oe) |-> (mem_rdata_o == pd_out));
endmodule

// File: rtl/bitio_parport.sv
module bitio_parport
    import pp_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [15:0]         bio_addr,
    input  logic                bio_wr,
    input  logic                bio_wval,
    output logic                bio_rbit,
    input  logic [15:0]         mem_addr,
    input  logic                mem_wr,
    input  logic [DW-1:0]       mem_wdata,
    output logic [DW-1:0]       mem_rdata,
    input  logic [NPORT*DW-1:0] pd_in,
    output logic [NPORT*DW-1:0] pd_out,
    output logic [NPORT-1:0]    pd_oe,
    input  logic [NPORT-1:0]    st_err,
    input  logic [NPORT-1:0]    st_sel,
    input  logic [NPORT-1:0]    st_pend,
    input  logic [NPORT-1:0]    st_ack,
    input  logic [NPORT-1:0]    st_busy,
    output logic [NPORT-1:0]    ctl_strobe_n,
    output logic [NPORT-1:0]    ctl_autolf_n,
    output logic [NPORT-1:0]    ctl_init,
    output logic [NPORT-1:0]    ctl_selpr_n,
    output logic [NPORT-1:0]    ctl_spare,
    output logic [NPORT-1:0]    tern_en,
    output logic [NPORT-1:0]    led
);
    logic [NPORT-1:0]    bio_hits;
    logic [NPORT-1:0]    mem_hits;
    logic [NPORT-1:0]    rbits;
    logic [DW-1:0]       rbytes [NPORT];

    for (genvar k = 0; k < NPORT; k++) begin : g_port
        stat_t st;
        assign st = '{busy: st_busy[k], ack: st_ack[k], pend: st_pend[k],
                      sel: st_sel[k], err: st_err[k]};

        pp_port #(
            .BIO_BASE(bio_base(k)),
            .MEM_BASE(mem_base(k))
        ) u_port (
            .clk(clk), .rst(rst),
            .bio_addr(bio_addr), .bio_wr(bio_wr), .bio_wval(bio_wval),
            .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
            .pd_in(pd_in[k*DW +: DW]), .st_pins(st),
            .pd_out(pd_out[k*DW +: DW]), .pd_oe(pd_oe[k]),
            .strobe_n(ctl_strobe_n[k]), .autolf_n(ctl_autolf_n[k]),
            .init_p(ctl_init[k]), .selpr_n(ctl_selpr_n[k]),
            .spare_p(ctl_spare[k]), .tern_p(tern_en[k]), .led_p(led[k]),
            .bio_hit_o(bio_hits[k]), .bio_rbit_o(rbits[k]),
            .mem_hit_o(mem_hits[k]), .mem_rdata_o(rbytes[k])
        );
    end

    always_comb begin
        bio_rbit  = 1'b0;
        mem_rdata = '0;
        for (int k = 0; k < NPORT; k++) begin
            bio_rbit  = bio_rbit | rbits[k];
            mem_rdata = mem_rdata | rbytes[k];
        end
    end

    // R2: at most one port claims a bit-bus address
    a_r2_single_hit: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bio_hits));

    // R2: no port claims it -> test returns 0
    a_r2_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bio_hits == '0) |-> !bio_rbit);

    // R10: memory miss reads 0
    a_r10_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (mem_hits == '0) |-> (mem_rdata == '0));

    // R10: memory write to a miss leaves all latches as they were
    a_r10_miss_no_write: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_hits == '0) |=> $stable(pd_out));
endmodule

// File: tb/test_bitio_parport.sv
module test_bitio_parport;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [15:0]  bio_addr;
    logic         bio_wr, bio_wval, bio_rbit;
    logic [15:0]  mem_addr;
    logic         mem_wr;
    logic [7:0]   mem_wdata, mem_rdata;
    logic [31:0]  pd_in, pd_out;
    logic [3:0]   pd_oe, st_err, st_sel, st_pend, st_ack, st_busy;
    logic [3:0]   ctl_strobe_n, ctl_autolf_n, ctl_init, ctl_selpr_n, ctl_spare, tern_en, led;

    always #4 clk = ~clk;

    bitio_parport i_bitio_parport (
        .clk(clk), .rst(rst),
        .bio_addr(bio_addr), .bio_wr(bio_wr), .bio_wval(bio_wval), .bio_rbit(bio_rbit),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
        .st_err(st_err), .st_sel(st_sel), .st_pend(st_pend), .st_ack(st_ack), .st_busy(st_busy),
        .ctl_strobe_n(ctl_strobe_n), .ctl_autolf_n(ctl_autolf_n), .ctl_init(ctl_init),
        .ctl_selpr_n(ctl_selpr_n), .ctl_spare(ctl_spare), .tern_en(tern_en), .led(led)
    );

    typedef struct {
        int          kind;   // 0 bit test, 1 memory byte, 2 pin vector
        int          port;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model, built from the requirements
    logic [4:0] m_ctl [N];
    logic       m_dir [N];
    logic       m_led [N];
    logic [7:0] m_lat [N];

    function automatic logic [15:0] obs_pins(int k);
        return {pd_out[k*8 +: 8], ctl_strobe_n[k], ctl_autolf_n[k], ctl_init[k],
                ctl_selpr_n[k], ctl_spare[k], tern_en[k], led[k], pd_oe[k]};
    endfunction

    function automatic logic [15:0] exp_pins(int k);
        return {m_lat[k], ~m_ctl[k][0], ~m_ctl[k][1], m_ctl[k][2], ~m_ctl[k][3],
                m_ctl[k][4], m_ctl[k][3], m_led[k], ~m_dir[k]};
    endfunction

    // monitor: samples away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = q.pop_front();
                case (it.kind)
                    0:       act = {15'd0, bio_rbit};
                    1:       act = {8'd0, mem_rdata};
                    default: act = obs_pins(it.port);
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic bio_write(input logic [15:0] a, input logic v);
        @(negedge clk);
        bio_addr = a; bio_wval = v; bio_wr = 1'b1;
        if (a[15:6] == 10'h040) begin
            int k = int'(a[5:4]);
            int ix = int'(a[3:0]);
            if (ix < 5)       m_ctl[k][ix] = v;
            else if (ix == 5) m_dir[k] = v;
            else if (ix == 6) m_led[k] = v;
        end
        @(negedge clk);
        bio_wr = 1'b0;
    endtask

    task automatic mem_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        mem_addr = a; mem_wdata = d; mem_wr = 1'b1;
        if (a[15:3] == 13'h0A00 && a[0] == 1'b0) m_lat[int'(a[2:1])] = d;
        @(negedge clk);
        mem_wr = 1'b0;
    endtask

    task automatic chk_bit(input logic [15:0] a, input logic e, input string tag);
        @(negedge clk);
        bio_addr = a;
        q.push_back('{0, 0, {15'd0, e}, tag});
    endtask

    task automatic chk_mem(input logic [15:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        mem_addr = a;
        q.push_back('{1, 0, {8'd0, e}, tag});
    endtask

    task automatic chk_pins(input int k, input string tag);
        @(negedge clk);
        q.push_back('{2, k, exp_pins(k), tag});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bio_addr = '0; bio_wr = 0; bio_wval = 0;
        mem_addr = '0; mem_wr = 0; mem_wdata = '0; pd_in = '0;
        st_err = '0; st_sel = '0; st_pend = '0; st_ack = '0; st_busy = '0;
        for (int k = 0; k < N; k++) begin
            m_ctl[k] = '0; m_dir[k] = 0; m_led[k] = 0; m_lat[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state on every port
        for (int k = 0; k < N; k++) chk_pins(k, "R1 reset pins");
        chk_bit(16'h1000, 1'b1, "R6 card present");
        chk_bit(16'h1001, 1'b0, "R1 direction after reset");
        chk_bit(16'h1032, 1'b0, "R1 LED after reset");

        // R3 R4: each control bit on port 0, then cleared again
        for (int i = 0; i < 5; i++) begin
            bio_write(16'h1000 + 16'(i), 1'b1);
            chk_pins(0, "R3 R4 set control");
        end
        bio_write(16'h1000, 1'b0);
        bio_write(16'h1002, 1'b0);
        chk_pins(0, "R3 R4 clear control");

        // R5: select-printer on port 2 gives ternary enable
        bio_write(16'h1023, 1'b1);
        chk_pins(2, "R5 tern enable");
        chk_pins(0, "R2 port 0 untouched by port 2 write");

        // R3 R6: LED write and readback
        bio_write(16'h1016, 1'b1);
        chk_pins(1, "R3 LED pin");
        chk_bit(16'h1012, 1'b1, "R6 LED readback");

        // R6: status inputs through the synchroniser on port 1
        @(negedge clk);
        st_err = 4'b0010; st_pend = 4'b0010; st_busy = 4'b0010; st_sel = 4'b1000; st_ack = 4'b0000;
        repeat (3) @(negedge clk);
        chk_bit(16'h1013, 1'b1, "R6 error");
        chk_bit(16'h1014, 1'b0, "R6 select");
        chk_bit(16'h1015, 1'b1, "R6 paper end");
        chk_bit(16'h1016, 1'b0, "R6 acknowledge");
        chk_bit(16'h1017, 1'b1, "R6 busy");
        chk_bit(16'h1034, 1'b1, "R6 select port 3");

        // R7: unused indices
        chk_bit(16'h1019, 1'b0, "R7 test index 9");
        chk_bit(16'h100F, 1'b0, "R7 test index 15");
        bio_write(16'h1007, 1'b1);
        bio_write(16'h1008, 1'b1);
        chk_pins(0, "R7 write index 7/8 ignored");
        chk_bit(16'h1001, 1'b0, "R7 direction unchanged");

        // R2: out-of-range bit addresses
        bio_write(16'h1040, 1'b1);
        bio_write(16'h0005, 1'b1);
        for (int k = 0; k < N; k++) chk_pins(k, "R2 foreign write ignored");
        chk_bit(16'h1040, 1'b0, "R2 foreign test reads 0");
        chk_bit(16'h2000, 1'b0, "R2 foreign test reads 0");

        // R8 R9: data registers
        mem_write(16'h5004, 8'hA5);
        mem_write(16'h5000, 8'h5A);
        chk_pins(2, "R8 latch drives pins");
        chk_pins(0, "R8 latch drives pins");
        chk_mem(16'h5004, 8'hA5, "R9 output readback");
        chk_mem(16'h5006, 8'h00, "R9 untouched latch");

        // R10: non-register addresses
        mem_write(16'h5001, 8'hFF);
        mem_write(16'h5008, 8'hFF);
        for (int k = 0; k < N; k++) chk_pins(k, "R10 foreign memory write ignored");
        chk_mem(16'h5001, 8'h00, "R10 odd address reads 0");
        chk_mem(16'h4000, 8'h00, "R10 foreign read 0");

        // R9 R3: input mode on port 3
        mem_write(16'h5006, 8'h81);
        @(negedge clk);
        pd_in = 32'h3C00_0000;
        bio_write(16'h1035, 1'b1);
        repeat (3) @(negedge clk);
        chk_pins(3, "R3 R4 input mode releases pins");
        chk_bit(16'h1031, 1'b1, "R6 direction readback");
        chk_mem(16'h5006, 8'h3C, "R9 input sample");
        bio_write(16'h1035, 1'b0);
        chk_mem(16'h5006, 8'h81, "R9 latch kept across direction");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule